// File: doc/BRIEF.md
# XON/XOFF Software Flow Controller

This block carries out in-band software flow control beside a UART. On the receive path it compares each arriving character against four programmable control characters: two resume codes (on A, on B) and two pause codes (off A, off B). A matched pause code holds the local transmitter, and a matched resume code releases it. Matched control characters are removed from the data stream that goes on to the receive FIFO, and each one sets a sticky status flag.

On the transmit path it watches the fill level of the local receive FIFO. When the level climbs to the halt threshold it asks the serializer to insert a pause code. When the level later drains to the resume threshold it asks for a resume code. Both thresholds are 4-bit values counted in steps of 8 words of a 128-word FIFO. Two independent 2-bit selectors choose which code pair, or both pairs, is matched on receive and which is generated on transmit. A global enable must be set for any of this to act.

Top module: `inline_flow_ctrl`

## Requirements
- R1: After reset `rx_out_valid`, `tx_pause`, `ins_req` and `stat_flags` are all 0.
- R2: With `cfg_sw_en`=1 and `cfg_rx_pairs`=01 (B pair) or 10 (A pair), a received character equal to a code of the selected pair is dropped from the output stream and sets its flag: bit 0 on A, bit 1 on B, bit 2 off A, bit 3 off B. Every other character passes through in order, one cycle after its strobe.
- R3: With `cfg_rx_pairs`=11, a match needs on A followed at once by on B (flags 0 and 1), or off A followed at once by off B (flags 2 and 3). Both characters of a matched pair are dropped. A first character that is not followed by its partner is passed on as data, in arrival order.
- R4: A matched pause code raises `tx_pause` only in a cycle where `tx_busy` is low, so a character in progress finishes first. A matched resume code clears `tx_pause` whatever the state of `tx_busy`.
- R5: With `cfg_sw_en`=0 or `cfg_rx_pairs`=00, no character is matched, all characters pass through, no flag is set and `tx_pause` is 0.
- R6: A `stat_rd` pulse clears all four flags in the next cycle.
- R7: A pause insertion is requested once when `rx_fifo_level` rises to `cfg_halt_lvl`×8 or above. A resume insertion is requested once when the level later falls to `cfg_resume_lvl`×8 or below. Movements between the two thresholds request nothing.
- R8: With `cfg_tx_pairs`=01 the inserted codes are off B and on B. With 10 they are off A and on A. With 11 they are off A then off B, or on A then on B. With 00, or with `cfg_sw_en`=0, nothing is inserted.
- R9: `ins_req` stays high and `ins_char` stays stable until `ins_ack` is seen. Each acknowledge completes one character.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_sw_en | input | 1 | Global software flow enable |
| cfg_rx_pairs | input | 2 | Receive match selector (00 off, 01 B pair, 10 A pair, 11 both) |
| cfg_tx_pairs | input | 2 | Transmit generate selector (same encoding) |
| cfg_on_a | input | 8 | Resume code A |
| cfg_on_b | input | 8 | Resume code B |
| cfg_off_a | input | 8 | Pause code A |
| cfg_off_b | input | 8 | Pause code B |
| cfg_halt_lvl | input | 4 | Halt threshold in units of 8 words |
| cfg_resume_lvl | input | 4 | Resume threshold in units of 8 words |
| rx_valid | input | 1 | Received character strobe (at most one every other cycle) |
| rx_char | input | 8 | Received character |
| rx_fifo_level | input | 8 | Local receive FIFO fill level, 0 to 128 |
| stat_rd | input | 1 | Status read pulse, clears the flags |
| tx_busy | input | 1 | Serializer is shifting a character |
| ins_ack | input | 1 | Serializer has taken the inserted character |
| rx_out_valid | output | 1 | Data character strobe toward the receive FIFO |
| rx_out_char | output | 8 | Data character toward the receive FIFO |
| stat_flags | output | 4 | Sticky detect flags: on A, on B, off A, off B |
| tx_pause | output | 1 | Hold the local transmitter |
| ins_req | output | 1 | Request to insert a control character |
| ins_char | output | 8 | Control character to insert |

## Verification
A wrong pairing state shows up at the data port within one or two characters. A held first character either goes missing, is emitted twice, or comes out of order against its successor. A flag appears without its character, or a flag for the other pair is set. A stale pause request shows on `tx_pause` two cycles after the matching strobe. A lost halt/resume memory shows on the insertion port as a repeated or missing request, and the FIFO level at which that request appears exposes an off-by-one threshold at once.

// File: rtl/flow_pkg.sv
package flow_pkg;

    typedef enum logic [1:0] {
        SEL_OFF  = 2'b00,
        SEL_B    = 2'b01,
        SEL_A    = 2'b10,
        SEL_BOTH = 2'b11
    } pair_sel_e;

    typedef enum logic [1:0] {
        SEQ_IDLE   = 2'b00,
        SEQ_FIRST  = 2'b01,
        SEQ_SECOND = 2'b10
    } ins_seq_e;

    // index of each control character in the compare vector / flag vector
    localparam int IDX_ON_A  = 0;
    localparam int IDX_ON_B  = 1;
    localparam int IDX_OFF_A = 2;
    localparam int IDX_OFF_B = 3;
    localparam int NUM_CODES = 4;

endpackage

// File: rtl/flow_char_cmp.sv
module flow_char_cmp #(
    parameter int CHAR_W = 8,
    parameter int N      = 4
) (
    input  logic [CHAR_W-1:0]         rx_char,
    input  logic [N-1:0][CHAR_W-1:0]  ref_chars,
    output logic [N-1:0]              hit
);
    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign hit[g] = (rx_char == ref_chars[g]);
    end
endmodule

// File: rtl/flow_rx_match.sv
module flow_rx_match
    import flow_pkg::*;
#(
    parameter int CHAR_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cfg_en,
    input  logic [1:0]            cfg_sel,
    input  logic                  rx_valid,
    input  logic [CHAR_W-1:0]     rx_char,
    input  logic [NUM_CODES-1:0]  hit,
    input  logic                  stat_rd,
    input  logic                  tx_busy,
    output logic                  out_valid,
    output logic [CHAR_W-1:0]     out_char,
    output logic [NUM_CODES-1:0]  flags,
    output logic                  tx_pause
);
    typedef struct packed {
        logic                 pend_v;
        logic                 pend_off;
        logic [CHAR_W-1:0]    pend_char;
        logic                 flush_v;
        logic [CHAR_W-1:0]    flush_char;
        logic                 out_v;
        logic [CHAR_W-1:0]    out_char;
        logic [NUM_CODES-1:0] flags;
        logic                 pause_req;
        logic                 tx_pause;
    } rx_state_t;

    localparam logic [NUM_CODES-1:0] MASK_A   = 4'b0101;
    localparam logic [NUM_CODES-1:0] MASK_B   = 4'b1010;
    localparam logic [NUM_CODES-1:0] PAIR_ON  = 4'b0011;
    localparam logic [NUM_CODES-1:0] PAIR_OFF = 4'b1100;

    rx_state_t state_q, state_d;

    pair_sel_e            sel_e;
    logic                 active, both, partner, first_hit;
    logic [NUM_CODES-1:0] mask, m_hit;
    logic                 e1_v, e2_v;
    logic [CHAR_W-1:0]    e1_c, e2_c;

    assign sel_e = pair_sel_e'(cfg_sel);

    always_comb begin
        state_d         = state_q;
        state_d.out_v   = 1'b0;
        state_d.flush_v = 1'b0;
        e1_v = 1'b0;  e1_c = '0;
        e2_v = 1'b0;  e2_c = '0;

        active    = cfg_en && (sel_e != SEL_OFF);
        both      = active && (sel_e == SEL_BOTH);
        mask      = (sel_e == SEL_A) ? MASK_A : ((sel_e == SEL_B) ? MASK_B : '1);
        m_hit     = hit & mask;
        first_hit = hit[IDX_ON_A] | hit[IDX_OFF_A];
        partner   = state_q.pend_off ? hit[IDX_OFF_B] : hit[IDX_ON_B];

        if (stat_rd) state_d.flags = '0;

        // a deferred data character always leaves first
        if (state_q.flush_v) begin
            e1_v = 1'b1;
            e1_c = state_q.flush_char;
        end

        // a held first character is released when pairing is no longer in force
        if (state_q.pend_v && !both) begin
            if (!e1_v) begin e1_v = 1'b1; e1_c = state_q.pend_char; end
            else       begin e2_v = 1'b1; e2_c = state_q.pend_char; end
            state_d.pend_v = 1'b0;
        end

        if (rx_valid) begin
            if (!active) begin
                if (!e1_v) begin e1_v = 1'b1; e1_c = rx_char; end
                else       begin e2_v = 1'b1; e2_c = rx_char; end
            end else if (!both) begin
                if (|m_hit) begin
                    state_d.flags = state_d.flags | m_hit;
                    state_d.pause_req = m_hit[IDX_OFF_A] | m_hit[IDX_OFF_B];
                end else begin
                    if (!e1_v) begin e1_v = 1'b1; e1_c = rx_char; end
                    else       begin e2_v = 1'b1; e2_c = rx_char; end
                end
            end else if (state_q.pend_v) begin
                if (partner) begin
                    state_d.flags     = state_d.flags | (state_q.pend_off ? PAIR_OFF : PAIR_ON);
                    state_d.pause_req = state_q.pend_off;
                    state_d.pend_v    = 1'b0;
                end else begin
                    if (!e1_v) begin e1_v = 1'b1; e1_c = state_q.pend_char; end
                    else       begin e2_v = 1'b1; e2_c = state_q.pend_char; end
                    state_d.pend_v = 1'b0;
                    if (first_hit) begin
                        state_d.pend_v    = 1'b1;
                        state_d.pend_char = rx_char;
                        state_d.pend_off  = !hit[IDX_ON_A];
                    end else begin
                        if (!e1_v) begin e1_v = 1'b1; e1_c = rx_char; end
                        else       begin e2_v = 1'b1; e2_c = rx_char; end
                    end
                end
            end else if (first_hit) begin
                state_d.pend_v    = 1'b1;
                state_d.pend_char = rx_char;
                state_d.pend_off  = !hit[IDX_ON_A];
            end else begin
                if (!e1_v) begin e1_v = 1'b1; e1_c = rx_char; end
                else       begin e2_v = 1'b1; e2_c = rx_char; end
            end
        end

        if (!active) state_d.pause_req = 1'b0;

        state_d.out_v = e1_v;
        if (e1_v) state_d.out_char = e1_c;
        state_d.flush_v = e2_v;
        if (e2_v) state_d.flush_char = e2_c;

        // pause only starts between characters, release is immediate
        state_d.tx_pause = state_q.pause_req & (state_q.tx_pause | ~tx_busy);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign out_valid = state_q.out_v;
    assign out_char  = state_q.out_char;
    assign flags     = state_q.flags;
    assign tx_pause  = state_q.tx_pause;
endmodule

// File: rtl/flow_tx_gen.sv
module flow_tx_gen
    import flow_pkg::*;
#(
    parameter int CHAR_W   = 8,
    parameter int LVL_W    = 8,
    parameter int THR_W    = 4,
    parameter int THR_UNIT = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_en,
    input  logic [1:0]           cfg_sel,
    input  logic [CHAR_W-1:0]    on_a,
    input  logic [CHAR_W-1:0]    on_b,
    input  logic [CHAR_W-1:0]    off_a,
    input  logic [CHAR_W-1:0]    off_b,
    input  logic [THR_W-1:0]     halt_lvl,
    input  logic [THR_W-1:0]     resume_lvl,
    input  logic [LVL_W-1:0]     level,
    input  logic                 ins_ack,
    output logic                 ins_req,
    output logic [CHAR_W-1:0]    ins_char
);
    localparam int THR_SHIFT = $clog2(THR_UNIT);
    localparam int CMP_W     = (LVL_W > THR_W + THR_SHIFT) ? LVL_W : THR_W + THR_SHIFT;

    typedef struct packed {
        ins_seq_e          st;
        logic              halted;
        logic              two;
        logic [CHAR_W-1:0] c0;
        logic [CHAR_W-1:0] c1;
    } tx_state_t;

    tx_state_t state_q, state_d;

    pair_sel_e        sel_e;
    logic [CMP_W-1:0] lvl_x, halt_w, res_w;
    logic             go;

    assign sel_e  = pair_sel_e'(cfg_sel);
    assign lvl_x  = CMP_W'(level);
    assign halt_w = CMP_W'(halt_lvl) << THR_SHIFT;
    assign res_w  = CMP_W'(resume_lvl) << THR_SHIFT;

    always_comb begin
        state_d = state_q;
        go      = cfg_en && (sel_e != SEL_OFF);
        unique case (state_q.st)
            SEQ_IDLE: begin
                if (go && !state_q.halted && (lvl_x >= halt_w)) begin
                    state_d.halted = 1'b1;
                    state_d.st     = SEQ_FIRST;
                    state_d.two    = (sel_e == SEL_BOTH);
                    state_d.c0     = (sel_e == SEL_B) ? off_b : off_a;
                    state_d.c1     = off_b;
                end else if (go && state_q.halted && (lvl_x <= res_w)) begin
                    state_d.halted = 1'b0;
                    state_d.st     = SEQ_FIRST;
                    state_d.two    = (sel_e == SEL_BOTH);
                    state_d.c0     = (sel_e == SEL_B) ? on_b : on_a;
                    state_d.c1     = on_b;
                end
            end
            SEQ_FIRST: begin
                if (ins_ack) state_d.st = state_q.two ? SEQ_SECOND : SEQ_IDLE;
            end
            SEQ_SECOND: begin
                if (ins_ack) state_d.st = SEQ_IDLE;
            end
            default: state_d.st = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign ins_req  = (state_q.st != SEQ_IDLE);
    assign ins_char = (state_q.st == SEQ_SECOND) ? state_q.c1 : state_q.c0;
endmodule

// File: rtl/inline_flow_ctrl.sv
module inline_flow_ctrl
    import flow_pkg::*;
#(
    parameter int CHAR_W     = 8,
    parameter int FIFO_DEPTH = 128,
    parameter int THR_W      = 4,
    parameter int THR_UNIT   = 8,
    localparam int LVL_W     = $clog2(FIFO_DEPTH + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cfg_sw_en,
    input  logic [1:0]            cfg_rx_pairs,
    input  logic [1:0]            cfg_tx_pairs,
    input  logic [CHAR_W-1:0]     cfg_on_a,
    input  logic [CHAR_W-1:0]     cfg_on_b,
    input  logic [CHAR_W-1:0]     cfg_off_a,
    input  logic [CHAR_W-1:0]     cfg_off_b,
    input  logic [THR_W-1:0]      cfg_halt_lvl,
    input  logic [THR_W-1:0]      cfg_resume_lvl,
    input  logic                  rx_valid,
    input  logic [CHAR_W-1:0]     rx_char,
    input  logic [LVL_W-1:0]      rx_fifo_level,
    input  logic                  stat_rd,
    input  logic                  tx_busy,
    input  logic                  ins_ack,
    output logic                  rx_out_valid,
    output logic [CHAR_W-1:0]     rx_out_char,
    output logic [NUM_CODES-1:0]  stat_flags,
    output logic                  tx_pause,
    output logic                  ins_req,
    output logic [CHAR_W-1:0]     ins_char
);
    logic [NUM_CODES-1:0][CHAR_W-1:0] codes;
    logic [NUM_CODES-1:0]             hit;

    assign codes[IDX_ON_A]  = cfg_on_a;
    assign codes[IDX_ON_B]  = cfg_on_b;
    assign codes[IDX_OFF_A] = cfg_off_a;
    assign codes[IDX_OFF_B] = cfg_off_b;

    flow_char_cmp #(.CHAR_W(CHAR_W), .N(NUM_CODES)) u_cmp (
        .rx_char   (rx_char),
        .ref_chars (codes),
        .hit       (hit)
    );

    flow_rx_match #(.CHAR_W(CHAR_W)) u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_en    (cfg_sw_en),
        .cfg_sel   (cfg_rx_pairs),
        .rx_valid  (rx_valid),
        .rx_char   (rx_char),
        .hit       (hit),
        .stat_rd   (stat_rd),
        .tx_busy   (tx_busy),
        .out_valid (rx_out_valid),
        .out_char  (rx_out_char),
        .flags     (stat_flags),
        .tx_pause  (tx_pause)
    );

    flow_tx_gen #(
        .CHAR_W   (CHAR_W),
        .LVL_W    (LVL_W),
        .THR_W    (THR_W),
        .THR_UNIT (THR_UNIT)
    ) u_tx (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_en     (cfg_sw_en),
        .cfg_sel    (cfg_tx_pairs),
        .on_a       (cfg_on_a),
        .on_b       (cfg_on_b),
        .off_a      (cfg_off_a),
        .off_b      (cfg_off_b),
        .halt_lvl   (cfg_halt_lvl),
        .resume_lvl (cfg_resume_lvl),
        .level      (rx_fifo_level),
        .ins_ack    (ins_ack),
        .ins_req    (ins_req),
        .ins_char   (ins_char)
    );
endmodule

// File: rtl/flow_ctrl_chk.sv
module flow_ctrl_chk #(
    parameter int CHAR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_sw_en,
    input logic              rx_valid,
    input logic              stat_rd,
    input logic              tx_busy,
    input logic              ins_ack,
    input logic [3:0]        stat_flags,
    input logic              tx_pause,
    input logic              ins_req,
    input logic [CHAR_W-1:0] ins_char
);
    AST_INS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (ins_req && !ins_ack) |=> (ins_req && $stable(ins_char))); // R9

    AST_PAUSE_BETWEEN_CHARS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_pause) |-> !$past(tx_busy)); // R4

    AST_PAUSE_OFF_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(cfg_sw_en) && !$past(cfg_sw_en, 2)) |-> !tx_pause); // R5

    AST_FLAGS_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && !rx_valid) |=> (stat_flags == 4'b0000)); // R6

    AST_FLAG_NEEDS_CHAR: assert property (@(posedge clk) disable iff (!rst_n)
        ((stat_flags & ~$past(stat_flags)) != 4'b0000) |-> $past(rx_valid)); // R2

    AST_NO_INSERT_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        (!ins_req && !cfg_sw_en) |=> !ins_req); // R8
endmodule

bind inline_flow_ctrl flow_ctrl_chk #(.CHAR_W(CHAR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_sw_en  (cfg_sw_en),
    .rx_valid   (rx_valid),
    .stat_rd    (stat_rd),
    .tx_busy    (tx_busy),
    .ins_ack    (ins_ack),
    .stat_flags (stat_flags),
    .tx_pause   (tx_pause),
    .ins_req    (ins_req),
    .ins_char   (ins_char)
);

// File: tb/tb_inline_flow_ctrl.sv
`timescale 1ns/1ps
module tb_inline_flow_ctrl;
    localparam logic [7:0] ON_A = 8'h11, ON_B = 8'h91, OFF_A = 8'h13, OFF_B = 8'h93;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_sw_en = 1'b0;
    logic [1:0] cfg_rx_pairs = 2'b00, cfg_tx_pairs = 2'b00;
    logic [3:0] cfg_halt_lvl = 4'd0, cfg_resume_lvl = 4'd0;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_char = 8'h00;
    logic [7:0] rx_fifo_level = 8'd0;
    logic       stat_rd = 1'b0, tx_busy = 1'b0, ins_ack = 1'b0;
    logic       rx_out_valid, tx_pause, ins_req;
    logic [7:0] rx_out_char, ins_char;
    logic [3:0] stat_flags;

    int checks = 0, fails = 0;
    logic [7:0] out_log [32];
    int         out_n = 0;
    logic [7:0] ins_log [32];
    int         ins_lvl [32];
    int         ins_n = 0;

    always #4 clk = ~clk;

    inline_flow_ctrl dut (
        .clk(clk), .rst_n(rst_n), .cfg_sw_en(cfg_sw_en),
        .cfg_rx_pairs(cfg_rx_pairs), .cfg_tx_pairs(cfg_tx_pairs),
        .cfg_on_a(ON_A), .cfg_on_b(ON_B), .cfg_off_a(OFF_A), .cfg_off_b(OFF_B),
        .cfg_halt_lvl(cfg_halt_lvl), .cfg_resume_lvl(cfg_resume_lvl),
        .rx_valid(rx_valid), .rx_char(rx_char), .rx_fifo_level(rx_fifo_level),
        .stat_rd(stat_rd), .tx_busy(tx_busy), .ins_ack(ins_ack),
        .rx_out_valid(rx_out_valid), .rx_out_char(rx_out_char),
        .stat_flags(stat_flags), .tx_pause(tx_pause),
        .ins_req(ins_req), .ins_char(ins_char)
    );

    // output stream monitor
    always @(negedge clk) begin
        if (rx_out_valid && out_n < 32) begin
            out_log[out_n] = rx_out_char;
            out_n = out_n + 1;
        end
    end

    // serializer model: acknowledge every requested character once
    always @(negedge clk) begin
        if (ins_req && !ins_ack) begin
            if (ins_n < 32) begin
                ins_log[ins_n] = ins_char;
                ins_lvl[ins_n] = int'(rx_fifo_level);
                ins_n = ins_n + 1;
            end
            ins_ack <= 1'b1;
        end else begin
            ins_ack <= 1'b0;
        end
    end

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic send(input logic [7:0] c);
        @(negedge clk); rx_valid = 1'b1; rx_char = c;
        @(negedge clk); rx_valid = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic read_flags();
        @(negedge clk); stat_rd = 1'b1;
        @(negedge clk); stat_rd = 1'b0;
    endtask

    // common receive sequence
    logic [7:0] seq [11];
    initial begin
        seq[0] = ON_A;  seq[1] = ON_B;  seq[2] = OFF_A; seq[3] = OFF_B;
        seq[4] = 8'h41; seq[5] = ON_A;  seq[6] = 8'h42; seq[7] = ON_A;
        seq[8] = OFF_A; seq[9] = OFF_B; seq[10] = OFF_B;
    end

    task automatic rx_case(input bit en, input logic [1:0] sel);
        logic [7:0] exp [11];
        int         exp_n;
        logic [3:0] exp_flags;
        bit         exp_pause;
        string      rq;
        cfg_sw_en = en; cfg_rx_pairs = sel;
        read_flags();
        @(posedge clk); out_n = 0;
        for (int i = 0; i < 11; i++) send(seq[i]);
        repeat (4) @(negedge clk);
        exp_n = 0;
        if (!en || sel == 2'b00) begin
            rq = "R5";
            for (int i = 0; i < 11; i++) begin exp[exp_n] = seq[i]; exp_n++; end
            exp_flags = 4'h0; exp_pause = 1'b0;
        end else if (sel != 2'b11) begin
            rq = "R2";
            for (int i = 0; i < 11; i++) begin
                bit drop;
                drop = (sel == 2'b01) ? (seq[i] == ON_B || seq[i] == OFF_B)
                                      : (seq[i] == ON_A || seq[i] == OFF_A);
                if (!drop) begin exp[exp_n] = seq[i]; exp_n++; end
            end
            exp_flags = (sel == 2'b01) ? 4'hA : 4'h5; exp_pause = 1'b1;
        end else begin
            rq = "R3";
            exp[0] = 8'h41; exp[1] = ON_A; exp[2] = 8'h42; exp[3] = ON_A; exp[4] = OFF_B;
            exp_n = 5; exp_flags = 4'hF; exp_pause = 1'b1;
        end
        chk(out_n == exp_n, rq, "stream length", out_n, exp_n);
        for (int i = 0; i < exp_n && i < out_n; i++)
            chk(out_log[i] == exp[i], rq, "stream char", int'(out_log[i]), int'(exp[i]));
        chk(stat_flags == exp_flags, rq, "flags", int'(stat_flags), int'(exp_flags));
        chk(tx_pause == exp_pause, "R4", "pause after sequence", int'(tx_pause), int'(exp_pause));
        read_flags();
        @(negedge clk);
        chk(stat_flags == 4'h0, "R6", "flags after read", int'(stat_flags), 0);
    endtask

    task automatic ramp(input logic [1:0] tsel, input int h, input int r);
        cfg_sw_en = 1'b1; cfg_tx_pairs = tsel;
        cfg_halt_lvl = 4'(h); cfg_resume_lvl = 4'(r);
        @(posedge clk); ins_n = 0;
        for (int l = 0; l <= 128; l++) begin
            @(negedge clk); rx_fifo_level = 8'(l); @(negedge clk);
        end
        for (int l = 128; l >= 0; l--) begin
            @(negedge clk); rx_fifo_level = 8'(l); @(negedge clk);
        end
        repeat (10) @(negedge clk);
    endtask

    task automatic tx_check(input logic [1:0] tsel, input int h, input int r);
        int n_exp;
        logic [7:0] e [4];
        case (tsel)
            2'b01:   begin e[0] = OFF_B; e[1] = ON_B; n_exp = 2; end
            2'b10:   begin e[0] = OFF_A; e[1] = ON_A; n_exp = 2; end
            default: begin e[0] = OFF_A; e[1] = OFF_B; e[2] = ON_A; e[3] = ON_B; n_exp = 4; end
        endcase
        chk(ins_n == n_exp, "R7", "insert count", ins_n, n_exp);
        for (int i = 0; i < n_exp && i < ins_n; i++)
            chk(ins_log[i] == e[i], "R8", "insert char", int'(ins_log[i]), int'(e[i]));
        if (ins_n == n_exp) begin
            chk(ins_lvl[0] == h * 8, "R7", "halt level", ins_lvl[0], h * 8);
            chk(ins_lvl[n_exp/2] == r * 8, "R7", "resume level", ins_lvl[n_exp/2], r * 8);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(rx_out_valid == 1'b0, "R1", "out valid", int'(rx_out_valid), 0);
        chk(tx_pause == 1'b0, "R1", "pause", int'(tx_pause), 0);
        chk(ins_req == 1'b0, "R1", "insert req", int'(ins_req), 0);
        chk(stat_flags == 4'h0, "R1", "flags", int'(stat_flags), 0);

        // receive sweep over enable and every selector value
        for (int e = 0; e < 2; e++)
            for (int s = 0; s < 4; s++)
                rx_case(e[0], 2'(s));

        // R4 pause waits for the character in progress
        cfg_sw_en = 1'b1; cfg_rx_pairs = 2'b10;
        send(ON_A);
        tx_busy = 1'b1;
        send(OFF_A);
        repeat (3) @(negedge clk);
        chk(tx_pause == 1'b0, "R4", "pause while busy", int'(tx_pause), 0);
        tx_busy = 1'b0;
        repeat (3) @(negedge clk);
        chk(tx_pause == 1'b1, "R4", "pause after idle", int'(tx_pause), 1);
        tx_busy = 1'b1;
        send(ON_A);
        chk(tx_pause == 1'b0, "R4", "release while busy", int'(tx_pause), 0);
        tx_busy = 1'b0;
        read_flags();

        // R8 no generation when the selector is off
        ramp(2'b00, 6, 2);
        chk(ins_n == 0, "R8", "inserts with selector off", ins_n, 0);

        // threshold sweep across pair selections
        for (int h = 1; h <= 15; h += 2) begin
            ramp(2'(((h / 2) % 3) + 1), h, h / 2);
            tx_check(2'(((h / 2) % 3) + 1), h, h / 2);
        end

        // R7 hysteresis: moves between thresholds request nothing
        cfg_tx_pairs = 2'b10; cfg_halt_lvl = 4'd4; cfg_resume_lvl = 4'd1;
        @(posedge clk); ins_n = 0;
        @(negedge clk); rx_fifo_level = 8'd32; repeat (10) @(negedge clk);
        rx_fifo_level = 8'd20; repeat (10) @(negedge clk);
        rx_fifo_level = 8'd60; repeat (10) @(negedge clk);
        rx_fifo_level = 8'd9;  repeat (10) @(negedge clk);
        chk(ins_n == 1, "R7", "single pause between thresholds", ins_n, 1);
        rx_fifo_level = 8'd8;  repeat (10) @(negedge clk);
        rx_fifo_level = 8'd0;  repeat (10) @(negedge clk);
        rx_fifo_level = 8'd30; repeat (10) @(negedge clk);
        chk(ins_n == 2, "R7", "single resume", ins_n, 2);
        if (ins_n == 2) chk(ins_log[1] == ON_A, "R8", "resume char", int'(ins_log[1]), int'(ON_A));

        // R8 global enable off blocks generation
        cfg_sw_en = 1'b0;
        rx_fifo_level = 8'd120; repeat (10) @(negedge clk);
        chk(ins_n == 2, "R8", "inserts with enable off", ins_n, 2);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule